// File: doc/BRIEF.md
# Multiplexed Address/Data Read Sequencer

This block is a bus master that reads 16-bit words from an external memory over one shared bus that carries first an address and then data. Every phase is counted in whole clock cycles. On a request the block drives the start address, pulses an address latch strobe for two cycles, keeps the address on the bus for one more cycle, and then releases the bus. It then drops an active-low read strobe for a programmable number of cycles and captures the bus on the strobe's rising edge. Each captured word is returned with a one-cycle valid pulse.

Five configuration inputs shape the cycle. They set the strobe width, an optional hold cycle, a long flash recovery, the latch strobe polarity, and whether one latch cycle serves a whole burst of reads. In burst mode the external latch is expected to step its own address after each read. In single mode the block issues a fresh latch cycle, with the next address, for every word. A done flag marks the last word of the request. The configuration is taken only while the block is idle.

Top module: `mux_ad_read_seq`

## Requirements
- R1: The latch strobe is active for exactly 2 consecutive cycles per latch cycle, and the bus output is enabled with the address throughout.
- R2: The address stays driven for exactly 1 cycle after the latch strobe goes inactive, and the bus is then released. The bus is never driven while the read strobe is low.
- R3: The read strobe goes low exactly 2 cycles after the latch strobe goes inactive.
- R4: The read strobe stays low for `cfg_dur` cycles. A value of 0 gives 1 cycle.
- R5: In burst mode (`cfg_multi`=1), consecutive read strobes are separated by H+1 high cycles, where H=1 if `cfg_hold`=1 and H=0 otherwise.
- R6: After the last read strobe of a latch cycle, the read strobe stays high and the bus stays released for F+H+1 cycles before the next latch cycle or the return to idle. F=7 if `cfg_flash`=1 and F=0 otherwise.
- R7: `bus_in` is captured at the clock edge where the read strobe rises. `rdata_valid` is high for exactly the following cycle, with the captured word on `rdata`.
- R8: With `cfg_ale_low`=0 the latch strobe is active-high (idle level 0). With `cfg_ale_low`=1 it is active-low (idle level 1).
- R9: In single mode (`cfg_multi`=0), each latch cycle carries address `req_addr`+w for word w (modulo 2^16) and is followed by exactly one read strobe. In burst mode, one latch cycle carrying `req_addr` serves all words of the request.
- R10: `req_count` words are read, and 0 is treated as 1. `done` is high together with the `rdata_valid` of the last word. `req_ready` is high only while idle, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R11: Configuration inputs are sampled only while idle. Changes while a request is in progress have no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the timing unit |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | DW | Start word address |
| req_count | input | CW | Number of words (0 means 1) |
| cfg_dur | input | DURW | Read strobe width in cycles |
| cfg_hold | input | 1 | Adds one hold cycle |
| cfg_flash | input | 1 | Adds the long recovery |
| cfg_ale_low | input | 1 | Latch strobe active-low when 1 |
| cfg_multi | input | 1 | Burst of reads per latch cycle when 1 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| bus_oe | output | 1 | Output enable for the shared bus |
| bus_out | output | DW | Address driven on the shared bus |
| bus_in | input | DW | Value read from the shared bus |
| rdata | output | DW | Captured word |
| rdata_valid | output | 1 | One-cycle pulse per captured word |
| done | output | 1 | Marks the last word of a request |

## Verification
Some rules are checked by assertions on every cycle:
- the two-cycle latch strobe;
- the single address-hold cycle and the release of the bus;
- the fixed two-cycle step from the latch strobe to the read strobe;
- the absence of bus contention while the read strobe is low;
- the valid pulse following a rising read strobe;
- `done` appearing only with a valid word.

Other behaviour depends on the configuration and the word index, and only the bench sweep can show it:
- the programmed strobe width;
- the hold and flash gaps;
- the per-word addresses in single mode;
- the captured data values;
- the zero-count and zero-width cases;
- immunity to configuration changes in mid-request.

// File: rtl/mux_ad_read_seq.sv
module mux_ad_read_seq #(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int DURW      = 5,
  parameter int FLASH_CYC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_addr,
  input  logic [CW-1:0]   req_count,
  input  logic [DURW-1:0] cfg_dur,
  input  logic            cfg_hold,
  input  logic            cfg_flash,
  input  logic            cfg_ale_low,
  input  logic            cfg_multi,
  output logic            ale,
  output logic            rd_n,
  output logic            bus_oe,
  output logic [DW-1:0]   bus_out,
  input  logic [DW-1:0]   bus_in,
  output logic [DW-1:0]   rdata,
  output logic            rdata_valid,
  output logic            done
);
  localparam int TW = DURW + 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ALE, S_AHLD, S_TURN, S_STRB, S_GAP, S_RCV
  } st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [CW-1:0]  left;
  logic           fin;
  logic [DW-1:0]  addr_q;
  logic [DURW-1:0] dur_q;
  logic           hold_q, flash_q, low_q, multi_q;

  wire [TW-1:0] dur_eff = (dur_q == '0) ? TW'(1) : TW'(dur_q);
  wire [TW-1:0] rcv_len = TW'(hold_q) + TW'(1) + (flash_q ? TW'(FLASH_CYC) : TW'(0));
  wire          tdone   = (tmr == '0);

  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_ALE) ^ low_q;
  assign rd_n      = (st != S_STRB);
  assign bus_oe    = (st == S_ALE) || (st == S_AHLD);
  assign bus_out   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      left        <= '0;
      fin         <= 1'b0;
      addr_q      <= '0;
      dur_q       <= '0;
      hold_q      <= 1'b0;
      flash_q     <= 1'b0;
      low_q       <= 1'b0;
      multi_q     <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      done        <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      done        <= 1'b0;
      if (!tdone) tmr <= tmr - TW'(1);
      unique case (st)
        S_IDLE: begin
          dur_q   <= cfg_dur;
          hold_q  <= cfg_hold;
          flash_q <= cfg_flash;
          low_q   <= cfg_ale_low;
          multi_q <= cfg_multi;
          if (req_valid) begin
            addr_q <= req_addr;
            left   <= (req_count == '0) ? '0 : req_count - CW'(1);
            fin    <= 1'b0;
            tmr    <= TW'(1);
            st     <= S_ALE;
          end
        end
        S_ALE:  if (tdone) st <= S_AHLD;
        S_AHLD: st <= S_TURN;
        S_TURN: begin
          st  <= S_STRB;
          tmr <= dur_eff - TW'(1);
        end
        S_STRB: if (tdone) begin
          rdata       <= bus_in;
          rdata_valid <= 1'b1;
          done        <= (left == '0);
          fin         <= (left == '0);
          if (left != '0) left <= left - CW'(1);
          if (!multi_q) addr_q <= addr_q + DW'(1);
          if (left != '0 && multi_q) begin
            st  <= S_GAP;
            tmr <= TW'(hold_q);
          end else begin
            st  <= S_RCV;
            tmr <= rcv_len - TW'(1);
          end
        end
        S_GAP: if (tdone) begin
          st  <= S_STRB;
          tmr <= dur_eff - TW'(1);
        end
        S_RCV: if (tdone) begin
          if (fin) st <= S_IDLE;
          else begin
            st  <= S_ALE;
            tmr <= TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mux_ad_read_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic low_q,
  input logic rd_n,
  input logic bus_oe,
  input logic req_ready,
  input logic rdata_valid,
  input logic done
);
  logic ale_act;
  assign ale_act = ale ^ low_q;

  assert_ale_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_act) |=> ale_act);
  assert_ale_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_act && $past(ale_act)) |=> !ale_act);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_act) |-> bus_oe);
  assert_bus_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_act) |=> !bus_oe);
  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !rd_n));
  assert_rd_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_act) |-> ##2 $fell(rd_n));
  assert_capture_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> (rd_n && $past(!rd_n)));
  assert_done_with_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rdata_valid);
  assert_busy_when_reading_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !req_ready);
endmodule

bind mux_ad_read_seq mux_ad_read_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .low_q(low_q), .rd_n(rd_n),
  .bus_oe(bus_oe), .req_ready(req_ready), .rdata_valid(rdata_valid), .done(done)
);

// File: tb/test_mux_ad_read_seq.sv
module test_mux_ad_read_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready;
  logic [15:0] req_addr;
  logic [7:0]  req_count;
  logic [4:0]  cfg_dur;
  logic        cfg_hold, cfg_flash, cfg_ale_low, cfg_multi;
  logic        ale, rd_n, bus_oe, rdata_valid, done;
  logic [15:0] bus_out, bus_in, rdata;

  int checks = 0;
  int fails  = 0;

  mux_ad_read_seq i_mux_ad_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .cfg_dur(cfg_dur),
    .cfg_hold(cfg_hold), .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low),
    .cfg_multi(cfg_multi), .ale(ale), .rd_n(rd_n), .bus_oe(bus_oe),
    .bus_out(bus_out), .bus_in(bus_in), .rdata(rdata),
    .rdata_valid(rdata_valid), .done(done)
  );

  function automatic logic [15:0] mem(input logic [15:0] a);
    return (a * 16'd3) ^ 16'hA5C3;
  endfunction

  logic [15:0] lat = 16'h0;
  logic        prev_rd = 1'b1;
  logic        run_low = 1'b0;
  assign bus_in = !rd_n ? mem(lat) : 16'hDEAD;

  always @(negedge clk) begin
    if (bus_oe && (ale ^ run_low)) lat <= bus_out;
    else if (rd_n && !prev_rd) lat <= lat + 16'd1;
    prev_rd <= rd_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input int d, input bit h, input bit f, input bit lo, input bit mu,
                     input int n, input logic [15:0] a);
    int dd, ff, nn, total, ll;
    dd = (d == 0) ? 1 : d;
    ff = f ? 7 : 0;
    nn = (n == 0) ? 1 : n;
    ll = 5 + dd + ff + int'(h);
    if (mu) total = 4 + (nn - 1) * (dd + int'(h) + 1) + dd + ff + int'(h) + 1;
    else    total = nn * ll;
    cfg_dur = 5'(d); cfg_hold = h; cfg_flash = f; cfg_ale_low = lo; cfg_multi = mu;
    run_low = lo;
    @(negedge clk);
    chk(ale == lo, "R8 idle latch level", ale, lo);
    chk(req_ready, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_count = 8'(n);
    for (int k = 1; k <= total + 1; k++) begin
      bit ea, eo, er, ev, ed;
      int kk, w, o, j;
      logic [15:0] eaddr;
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        cfg_dur = ~5'(d); cfg_hold = ~h; cfg_flash = ~f; cfg_ale_low = ~lo; cfg_multi = ~mu;
        req_addr = ~a; req_count = 8'd7;
      end
      kk = k - 1;
      ea = 0; eo = 0; er = 0; ev = 0; ed = 0; w = 0; eaddr = a;
      if (kk < total) begin
        if (!mu) begin
          w = kk / ll; o = kk % ll;
          ea = (o < 2); eo = (o < 3);
          er = (o >= 4) && (o < 4 + dd);
          ev = (o == 4 + dd);
          eaddr = a + 16'(w);
        end else begin
          ea = (kk < 2); eo = (kk < 3);
          if (kk >= 4) begin
            j = kk - 4; w = j / (dd + int'(h) + 1); o = j % (dd + int'(h) + 1);
            if (w < nn) begin
              er = (o < dd);
              ev = (o == dd);
            end
          end
        end
        ed = ev && (w == nn - 1);
      end
      // R11: expectations use the configuration captured at acceptance only
      chk((ale ^ lo) == ea, "R1 R8 R9 latch strobe", ale, ea ^ lo);
      chk(bus_oe == eo, "R2 bus enable", bus_oe, eo);
      chk(rd_n == !er, "R3 R4 R5 R6 read strobe", rd_n, !er);
      chk(rdata_valid == ev, "R7 valid pulse", rdata_valid, ev);
      chk(done == ed, "R10 done", done, ed);
      chk(req_ready == (kk >= total), "R10 ready", req_ready, kk >= total);
      if (eo) chk(bus_out == eaddr, "R9 address on bus", bus_out, eaddr);
      if (ev) chk(rdata == mem(a + 16'(w)), "R7 R11 captured word", rdata, mem(a + 16'(w)));
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int durs[5] = '{0, 1, 2, 5, 31};
    int cnts[3] = '{0, 1, 3};
    int idx = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0;
    cfg_dur = '0; cfg_hold = 0; cfg_flash = 0; cfg_ale_low = 0; cfg_multi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(ale == 1'b0, "R8 reset latch level", ale, 0);
    chk(rd_n == 1'b1, "R4 reset read strobe", rd_n, 1);
    chk(bus_oe == 1'b0, "R2 reset bus enable", bus_oe, 0);
    chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    chk(rdata_valid == 1'b0, "R7 reset valid", rdata_valid, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    for (int mu = 0; mu < 2; mu++)
      for (int lo = 0; lo < 2; lo++)
        for (int f = 0; f < 2; f++)
          for (int h = 0; h < 2; h++)
            for (int di = 0; di < 5; di++)
              for (int ci = 0; ci < 3; ci++) begin
                run(durs[di], h[0], f[0], lo[0], mu[0], cnts[ci], 16'hFFFE + 16'(idx * 257));
                idx++;
              end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule